// File: doc/BRIEF.md
# Display power and vertical-retrace controller

This block sits beside an LCD panel controller and owns three things: the two enable bits that decide whether the panel is driven, a 2-bit power-state readback that walks toward fully on or fully off one step at a time, and a vertical-retrace interrupt built from a sticky status flag. A host writes a control register and an interrupt register through simple write strobes. Register contents and the power state are always visible on output ports.

The power sequencer aims for state 3 only when both enables are set. Any other combination, including the blanked setting where only the secondary enable is kept, aims for state 0. Each step waits a programmable number of clock cycles. A frame-start pulse from the external timing generator sets the retrace flag. Software clears the flag by writing a zero to it. The interrupt line is asserted while the flag and its enable are both set.

Top module: `disp_pwr_vsync`

## Requirements
- R1: After reset, both enable bits, the interrupt enable, the retrace flag, the power state and the interrupt output are all 0.
- R2: A control write (ctrlWr high at a clock edge) loads ctrlWrData, where bit 0 is the secondary enable and bit 1 is the main enable. The value appears on ctrlQ after that edge.
- R3: The power target is 3 only when both enable bits are set. With only the secondary bit, only the main bit, or neither bit set, the target is 0 and the power state never rises.
- R4: The power state changes by exactly one per step, toward the target. It never changes while it equals the target.
- R5: With a constant stepDelay D, the first step happens at the (D+2)th clock edge after the edge that wrote a new target. Each later step follows D+1 edges after the one before.
- R6: If the target changes while a sequence is under way, the state reverses from the step it has reached, without jumping.
- R7: An interrupt write (irqWr high) loads the interrupt enable from irqWrData bit 1. A frameStart pulse sets the retrace flag at the same edge.
- R8: The retrace flag stays set until an interrupt write carries 0 in bit 0. A write with 1 in bit 0 leaves the flag as it was and never sets it.
- R9: When frameStart coincides with a clearing write, the flag ends up set.
- R10: Writing all zeros to the interrupt register disables the interrupt and drops irqOut.
- R11: irqOut is high exactly when the interrupt enable and the retrace flag are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWr | input | 1 | Control register write strobe |
| ctrlWrData | input | 2 | Control write data: bit 1 main enable, bit 0 secondary enable |
| irqWr | input | 1 | Interrupt register write strobe |
| irqWrData | input | 2 | Interrupt write data: bit 1 enable, bit 0 retrace flag (0 clears) |
| stepDelay | input | DLY_W | Extra wait cycles per power step |
| frameStart | input | 1 | Vertical retrace pulse from the timing generator |
| ctrlQ | output | 2 | Current enable bits |
| irqEnQ | output | 1 | Current interrupt enable |
| retraceQ | output | 1 | Sticky retrace flag |
| pwrState | output | 2 | Power state, 0 off to 3 fully on |
| irqOut | output | 1 | Vertical-retrace interrupt |

## Verification
The assertions assume that stepDelay changes only while the power state rests at its target. The one-step and hold properties would still hold without that, but the timing that the counter encodes would lose its meaning. The stimulus changes stepDelay only between phases, after polling for the target. Write strobes and frameStart may arrive in any cycle, and in any combination within a cycle. The random phase drives all three freely to reach same-cycle collisions.

// File: rtl/dpv_pkg.sv
package dpv_pkg;
  localparam logic [1:0] PWR_OFF = 2'd0;
  localparam logic [1:0] PWR_ON  = 2'd3;

  // strobes from the sequencer control to the datapath
  typedef struct packed {
    logic cntClr;
    logic stepUp;
    logic stepDown;
  } seqStrobe_t;
endpackage

// File: rtl/dpv_regs.sv
module dpv_regs (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWr,
  input  logic [1:0] ctrlWrData,
  input  logic       irqWr,
  input  logic [1:0] irqWrData,
  input  logic       frameStart,
  output logic [1:0] ctrlQ,
  output logic       irqEnQ,
  output logic       retraceQ
);
  logic clearReq;
  assign clearReq = irqWr && !irqWrData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ    <= 2'b00;
      irqEnQ   <= 1'b0;
      retraceQ <= 1'b0;
    end else begin
      if (ctrlWr) ctrlQ <= ctrlWrData;
      if (irqWr) irqEnQ <= irqWrData[1];
      // a retrace event wins over a simultaneous clear
      retraceQ <= frameStart || (retraceQ && !clearReq);
    end
  end

  p_frame_sets_r7: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> retraceQ);
  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (retraceQ && !(irqWr && !irqWrData[0])) |=> retraceQ);
  p_zero_disables_r10: assert property (@(posedge clk) disable iff (!rstN)
    (irqWr && irqWrData == 2'b00) |=> !irqEnQ);
endmodule

// File: rtl/dpv_seq_ctl.sv
module dpv_seq_ctl
  import dpv_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       ctrlQ,
  input  logic [1:0]       pwrState,
  input  logic [DLY_W-1:0] waitCnt,
  input  logic [DLY_W-1:0] stepDelay,
  output seqStrobe_t       strb
);
  logic [1:0] target;
  logic [1:0] prevTarget;
  logic       atTarget;
  logic       retarget;
  logic       expire;

  assign target   = (ctrlQ == 2'b11) ? PWR_ON : PWR_OFF;
  assign atTarget = (pwrState == target);
  assign retarget = (target != prevTarget);
  assign expire   = (waitCnt == stepDelay);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevTarget <= PWR_OFF;
    else       prevTarget <= target;
  end

  always_comb begin
    strb.cntClr   = atTarget || retarget || expire;
    strb.stepUp   = !atTarget && !retarget && expire && (target > pwrState);
    strb.stepDown = !atTarget && !retarget && expire && (target < pwrState);
  end

  p_hold_at_target_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == target) |=> (pwrState == $past(pwrState)));
  p_no_rise_unless_on_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ != 2'b11) |=> (pwrState <= $past(pwrState)));
endmodule

// File: rtl/dpv_datapath.sv
module dpv_datapath
  import dpv_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  output logic [DLY_W-1:0] waitCnt,
  output logic [1:0]       pwrState
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt  <= '0;
      pwrState <= PWR_OFF;
    end else begin
      if (strb.cntClr) waitCnt <= '0;
      else             waitCnt <= waitCnt + 1'b1;
      if (strb.stepUp)        pwrState <= pwrState + 2'd1;
      else if (strb.stepDown) pwrState <= pwrState - 2'd1;
    end
  end

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.stepUp, strb.stepDown}));
  p_single_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState != $past(pwrState)) |->
      (({1'b0, $past(pwrState)} + 3'd1 == {1'b0, pwrState}) ||
       ({1'b0, pwrState} + 3'd1 == {1'b0, $past(pwrState)})));
endmodule

// File: rtl/disp_pwr_vsync.sv
module disp_pwr_vsync
  import dpv_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWr,
  input  logic [1:0]       ctrlWrData,
  input  logic             irqWr,
  input  logic [1:0]       irqWrData,
  input  logic [DLY_W-1:0] stepDelay,
  input  logic             frameStart,
  output logic [1:0]       ctrlQ,
  output logic             irqEnQ,
  output logic             retraceQ,
  output logic [1:0]       pwrState,
  output logic             irqOut
);
  seqStrobe_t       strb;
  logic [DLY_W-1:0] waitCnt;

  dpv_regs u_regs (
    .clk(clk), .rstN(rstN),
    .ctrlWr(ctrlWr), .ctrlWrData(ctrlWrData),
    .irqWr(irqWr), .irqWrData(irqWrData),
    .frameStart(frameStart),
    .ctrlQ(ctrlQ), .irqEnQ(irqEnQ), .retraceQ(retraceQ)
  );

  dpv_seq_ctl #(.DLY_W(DLY_W)) u_ctl (
    .clk(clk), .rstN(rstN), .ctrlQ(ctrlQ), .pwrState(pwrState),
    .waitCnt(waitCnt), .stepDelay(stepDelay), .strb(strb)
  );

  dpv_datapath #(.DLY_W(DLY_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .waitCnt(waitCnt), .pwrState(pwrState)
  );

  // R11: interrupt gated by its enable
  assign irqOut = irqEnQ && retraceQ;
endmodule

// File: tb/disp_pwr_vsync_bench.sv
module disp_pwr_vsync_bench;
  localparam int DLY_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWr = 1'b0;
  logic [1:0] ctrlWrData = '0;
  logic irqWr = 1'b0;
  logic [1:0] irqWrData = '0;
  logic [DLY_W-1:0] stepDelay = 8'd2;
  logic frameStart = 1'b0;
  logic [1:0] ctrlQ;
  logic irqEnQ, retraceQ, irqOut;
  logic [1:0] pwrState;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // behavioural reference state
  int mCtrl, mEn, mFlag, mPwr, mCnt, mPrevTgt;

  always #4 clk = ~clk;

  disp_pwr_vsync #(.DLY_W(DLY_W)) u_disp_pwr_vsync (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlWrData(ctrlWrData),
    .irqWr(irqWr), .irqWrData(irqWrData), .stepDelay(stepDelay),
    .frameStart(frameStart), .ctrlQ(ctrlQ), .irqEnQ(irqEnQ),
    .retraceQ(retraceQ), .pwrState(pwrState), .irqOut(irqOut)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCtrl = 0; mEn = 0; mFlag = 0; mPwr = 0; mCnt = 0; mPrevTgt = 0;
    end else begin
      int tgt;
      tgt = (mCtrl == 3) ? 3 : 0;
      if (mPwr == tgt || tgt != mPrevTgt) mCnt = 0;
      else if (mCnt == int'(stepDelay)) begin
        mCnt = 0;
        mPwr = (tgt > mPwr) ? mPwr + 1 : mPwr - 1;
      end else mCnt = mCnt + 1;
      mPrevTgt = tgt;
      if (ctrlWr) mCtrl = int'(ctrlWrData);
      if (irqWr) mEn = int'(irqWrData[1]);
      mFlag = (frameStart || (mFlag == 1 && !(irqWr && !irqWrData[0]))) ? 1 : 0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R2 ctrlQ", int'(ctrlQ), mCtrl);
      check("R4 pwrState", int'(pwrState), mPwr);
      check("R7 irqEnQ", int'(irqEnQ), mEn);
      check("R8 retraceQ", int'(retraceQ), mFlag);
      check("R11 irqOut", int'(irqOut), mEn & mFlag);
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrCtrl(input logic [1:0] v);
    ctrlWr = 1'b1; ctrlWrData = v;
    tick();
    ctrlWr = 1'b0;
  endtask

  task automatic wrIrq(input logic [1:0] v);
    irqWr = 1'b1; irqWrData = v;
    tick();
    irqWr = 1'b0;
  endtask

  task automatic waitPwr(input logic [1:0] v);
    for (int i = 0; i < 400 && pwrState != v; i++) tick();
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 ctrlQ", int'(ctrlQ), 0);
    check("R1 pwrState", int'(pwrState), 0);
    check("R1 irq", int'({irqEnQ, retraceQ, irqOut}), 0);
    rstN = 1'b1;
    tick();

    // R3: partial settings never raise the power state
    wrCtrl(2'b01);
    check("R2 secondary only", int'(ctrlQ), 1);
    repeat (12) tick();
    check("R3 blanked stays off", int'(pwrState), 0);
    wrCtrl(2'b10);
    repeat (12) tick();
    check("R3 main only stays off", int'(pwrState), 0);

    // R5: first step timing with D=2
    wrCtrl(2'b11);
    repeat (3) tick();
    check("R5 before first step", int'(pwrState), 0);
    tick();
    check("R5 first step", int'(pwrState), 1);
    repeat (2) tick();
    check("R5 between steps", int'(pwrState), 1);
    tick();
    check("R5 second step", int'(pwrState), 2);
    waitPwr(2'd3);
    check("R3 fully on", int'(pwrState), 3);

    // R4: blank walks down to off
    wrCtrl(2'b01);
    waitPwr(2'd0);
    check("R4 fully off", int'(pwrState), 0);

    // R6: reversal from the reached step
    wrCtrl(2'b11);
    waitPwr(2'd2);
    wrCtrl(2'b01);
    for (int i = 0; i < 50 && pwrState == 2'd2; i++) tick();
    check("R6 reverse from 2", int'(pwrState), 1);
    waitPwr(2'd0);

    // R5 with zero delay
    stepDelay = 8'd0;
    wrCtrl(2'b11);
    repeat (4) tick();
    check("R5 zero delay", int'(pwrState), 3);
    wrCtrl(2'b01);
    waitPwr(2'd0);

    // R7, R8, R11 interrupt path
    frameStart = 1'b1; tick(); frameStart = 1'b0;
    check("R7 flag set", int'(retraceQ), 1);
    check("R11 gated off", int'(irqOut), 0);
    wrIrq(2'b11);
    check("R11 irq asserted", int'(irqOut), 1);
    repeat (5) tick();
    check("R8 flag sticky", int'(retraceQ), 1);
    wrIrq(2'b10);
    check("R8 flag cleared", int'(retraceQ), 0);
    wrIrq(2'b11);
    check("R8 write one no set", int'(retraceQ), 0);
    // R9: collision keeps the flag
    frameStart = 1'b1; wrIrq(2'b10); frameStart = 1'b0;
    check("R9 set wins", int'(retraceQ), 1);
    // R10: all zeros disables
    wrIrq(2'b00);
    check("R10 enable off", int'(irqEnQ), 0);
    check("R10 irqOut low", int'(irqOut), 0);

    // mixed traffic against the model
    stepDelay = 8'd1;
    for (int i = 0; i < 600; i++) begin
      ctrlWr = ($urandom_range(0, 9) == 0);
      ctrlWrData = 2'($urandom_range(0, 3));
      irqWr = ($urandom_range(0, 5) == 0);
      irqWrData = 2'($urandom_range(0, 3));
      frameStart = ($urandom_range(0, 7) == 0);
      tick();
    end
    ctrlWr = 1'b0; irqWr = 1'b0; frameStart = 1'b0;
    tick();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule